// File: doc/BRIEF.md
# Posted Write Master Sequencer

This block is the master side of a bridge toward the target bus. It empties a queue of posted write words onto that bus. When words for a write are waiting at the head of the queue it raises its bus request. Once it holds the grant and sees the bus idle, it drives an address phase and then streams one word per clock. Every data phase carries a word that has already been taken from the queue into a holding register, so a target that accepts every phase sees no master wait states.

A burst ends for one of four reasons: the write's final word is delivered, the queue runs dry, the target terminates, or the latency timer has run out after the grant was withdrawn. After a retry, a disconnect, a dry queue or a lost grant, the block starts a new burst for the words not yet delivered. That burst begins at the original address plus four bytes for each word already delivered. After a target abort it drops the rest of that write and moves on to the next one.

The bus signals are simplified and active high. Parity, arbitration and configuration registers belong to other blocks.

Top module: `pw_master_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_o`, `frame_o`, `irdy_o` and `hd_pop_o` are low.
- R2: `req_o` rises one clock after `hd_valid_i` is first seen high. It does this even when the write is not yet complete in the queue.
- R3: `frame_o` rises only at a clock edge where `req_o`, `gnt_i` and work were present and both `bus_frame_i` and `bus_irdy_i` were low. During that address phase `ad_o` carries the write address: `hd_addr_i` for a fresh write, or the resume address.
- R4: `irdy_o` rises with the first word on `ad_o` in the clock right after the address phase. While the target accepts (`trdy_i` and `devsel_i`) and more words are queued, a new word follows every clock.
- R5: A data phase is the last one when its word carries `hd_last_i` or when no further word was queued behind it. In that phase `frame_o` is low and `irdy_o` is high. `irdy_o` falls one clock after the final transfer.
- R6: When the queue runs dry in mid-write, the burst ends. No new address phase occurs until more words arrive. The follow-on burst starts at the write address plus 4 times the number of words already delivered.
- R7: A retry (`stop_i` with `devsel_i`, no `trdy_i`) ends the burst with no transfer. A later burst resends the same word at the resume address.
- R8: A disconnect (`stop_i` with `trdy_i` and `devsel_i`) delivers the current word and ends the burst. The remaining words follow in a new burst at the resume address.
- R9: A target abort (`stop_i` without `devsel_i`) ends the burst. The rest of that write, up to and including its `hd_last_i` word, is popped and never driven. The next write then starts at its own `hd_addr_i`.
- R10: The latency counter loads `lat_timer_i` when `frame_o` rises and counts down once per clock while `frame_o` is high. Once it reaches zero with `gnt_i` low, the next phase is made the last one, and the rest follows in a later burst. While `gnt_i` stays high, an expired counter does not end the burst.
- R11: `hd_pop_o` is raised only while `hd_valid_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| hd_valid_i | input | 1 | Queue head holds a word |
| hd_more_i | input | 1 | At least one word sits behind the head |
| hd_data_i | input | DATA_W | Head word |
| hd_last_i | input | 1 | Head word is the final word of its write |
| hd_addr_i | input | ADDR_W | Start address of the write at the head |
| hd_pop_o | output | 1 | Remove the head word this clock |
| lat_timer_i | input | LAT_W | Programmed latency count |
| req_o | output | 1 | Bus request |
| gnt_i | input | 1 | Bus grant |
| bus_frame_i | input | 1 | Frame line as seen on the bus |
| bus_irdy_i | input | 1 | Initiator-ready line as seen on the bus |
| frame_o | output | 1 | Frame driven by this master |
| irdy_o | output | 1 | Initiator ready driven by this master |
| ad_o | output | DATA_W | Address or data driven on the bus |
| trdy_i | input | 1 | Target ready |
| stop_i | input | 1 | Target stop |
| devsel_i | input | 1 | Target device select |

## Verification
The request is due one clock after the head word shows up. The address phase is due one clock after a request meets a held grant and an idle bus. The first word follows one clock after the address phase, and further words follow every clock. The bench changes inputs 2 ns after a rising edge and reads outputs at the falling edge. The basic burst is checked on a fixed schedule: request at the second falling edge after the words are pushed, address at the third, first word at the fourth, last phase at the seventh and `irdy_o` low at the eighth. The termination cases are checked from a log of address phases and accepted words, built at falling edges, so resume addresses and burst lengths are compared exactly.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ADDR  = 2'd1,
        SEQ_DATA  = 2'd2,
        SEQ_FLUSH = 2'd3
    } seq_state_e;

    // byte address step per delivered word, as a shift amount
    localparam int unsigned WORD_SHIFT = 2;

endpackage

// File: rtl/pwm_lat_timer.sv
module pwm_lat_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         run_i,
    input  logic [W-1:0] init_i,
    output logic         expired_o
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = init_i;
        end else if (run_i && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/pwm_resume_addr.sv
module pwm_resume_addr
    import pwm_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture_i,
    input  logic [AW-1:0] base_i,
    input  logic          beat_i,
    input  logic          clear_i,
    output logic [AW-1:0] resume_o,
    output logic          zero_o
);

    typedef struct packed {
        logic [AW-1:0] base;
        logic [CW-1:0] cnt;
    } trk_t;

    trk_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (capture_i) begin
            t_d.base = base_i;
        end
        if (clear_i) begin
            t_d.cnt = '0;
        end else if (beat_i) begin
            t_d.cnt = t_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign resume_o = t_q.base + (AW'(t_q.cnt) << WORD_SHIFT);
    assign zero_o   = (t_q.cnt == '0);

endmodule

// File: rtl/pw_master_seq.sv
module pw_master_seq
    import pwm_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int LAT_W  = 8,
    parameter int BEAT_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hd_valid_i,
    input  logic              hd_more_i,
    input  logic [DATA_W-1:0] hd_data_i,
    input  logic              hd_last_i,
    input  logic [ADDR_W-1:0] hd_addr_i,
    output logic              hd_pop_o,
    input  logic [LAT_W-1:0]  lat_timer_i,
    output logic              req_o,
    input  logic              gnt_i,
    input  logic              bus_frame_i,
    input  logic              bus_irdy_i,
    output logic              frame_o,
    output logic              irdy_o,
    output logic [DATA_W-1:0] ad_o,
    input  logic              trdy_i,
    input  logic              stop_i,
    input  logic              devsel_i
);

    typedef struct packed {
        seq_state_e        st;
        logic              req;
        logic              frame;
        logic              irdy;
        logic              held;   // holding register carries an undelivered word
        logic              last;   // held word ends its write
        logic [DATA_W-1:0] data;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic              tmr_load, tmr_expired;
    logic              trk_cap, trk_beat, trk_clr, trk_zero;
    logic [ADDR_W-1:0] resume_addr;
    logic              pop;

    logic work, bus_idle, xfer, t_abort, t_stop, lat_end, more, last_w;

    pwm_lat_timer #(.W(LAT_W)) u_lat (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .run_i     (r_q.frame),
        .init_i    (lat_timer_i),
        .expired_o (tmr_expired)
    );

    pwm_resume_addr #(.AW(ADDR_W), .CW(BEAT_W)) u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (trk_cap),
        .base_i    (hd_addr_i),
        .beat_i    (trk_beat),
        .clear_i   (trk_clr),
        .resume_o  (resume_addr),
        .zero_o    (trk_zero)
    );

    always_comb begin
        r_d      = r_q;
        pop      = 1'b0;
        tmr_load = 1'b0;
        trk_cap  = 1'b0;
        trk_beat = 1'b0;
        trk_clr  = 1'b0;
        more     = 1'b0;
        last_w   = 1'b0;

        work     = r_q.held || hd_valid_i;
        bus_idle = !bus_frame_i && !bus_irdy_i;
        xfer     = r_q.irdy && trdy_i && devsel_i;
        t_abort  = r_q.irdy && stop_i && !devsel_i;
        t_stop   = r_q.irdy && stop_i;
        lat_end  = tmr_expired && !gnt_i;

        unique case (r_q.st)
            SEQ_IDLE: begin
                if (r_q.req && gnt_i && bus_idle && work) begin
                    r_d.st    = SEQ_ADDR;
                    r_d.frame = 1'b1;
                    tmr_load  = 1'b1;
                    trk_cap   = trk_zero && !r_q.held;
                end
            end

            SEQ_ADDR: begin
                r_d.st   = SEQ_DATA;
                r_d.irdy = 1'b1;
                if (r_q.held) begin
                    last_w = r_q.last;
                    more   = hd_valid_i;
                end else begin
                    pop      = 1'b1;
                    r_d.data = hd_data_i;
                    r_d.last = hd_last_i;
                    r_d.held = 1'b1;
                    last_w   = hd_last_i;
                    more     = hd_more_i;
                end
                r_d.frame = !(last_w || !more || lat_end);
            end

            SEQ_DATA: begin
                if (t_abort) begin
                    r_d.frame = 1'b0;
                    r_d.irdy  = 1'b0;
                    r_d.held  = 1'b0;
                    if (r_q.last) begin
                        trk_clr = 1'b1;
                        r_d.st  = SEQ_IDLE;
                    end else begin
                        r_d.st  = SEQ_FLUSH;
                    end
                end else if (xfer) begin
                    trk_beat = 1'b1;
                    trk_clr  = r_q.last;
                    r_d.held = 1'b0;
                    if (!r_q.frame || stop_i) begin
                        r_d.frame = 1'b0;
                        r_d.irdy  = 1'b0;
                        r_d.st    = SEQ_IDLE;
                    end else begin
                        pop       = 1'b1;
                        r_d.data  = hd_data_i;
                        r_d.last  = hd_last_i;
                        r_d.held  = 1'b1;
                        r_d.frame = !(hd_last_i || !hd_more_i || lat_end);
                    end
                end else if (t_stop) begin
                    r_d.frame = 1'b0;
                    r_d.irdy  = 1'b0;
                    r_d.st    = SEQ_IDLE;
                end else if (r_q.frame && lat_end) begin
                    r_d.frame = 1'b0;
                end
            end

            SEQ_FLUSH: begin
                if (hd_valid_i) begin
                    pop = 1'b1;
                    if (hd_last_i) begin
                        trk_clr = 1'b1;
                        r_d.st  = SEQ_IDLE;
                    end
                end
            end

            default: r_d.st = SEQ_IDLE;
        endcase

        r_d.req = (r_d.st != SEQ_FLUSH) && (r_d.held || hd_valid_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign hd_pop_o = pop;
    assign req_o    = r_q.req;
    assign frame_o  = r_q.frame;
    assign irdy_o   = r_q.irdy;
    assign ad_o     = (r_q.st == SEQ_ADDR) ? DATA_W'(resume_addr) : r_q.data;

endmodule

// File: rtl/pw_master_seq_chk.sv
module pw_master_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic frame_o,
    input logic irdy_o,
    input logic gnt_i,
    input logic bus_frame_i,
    input logic bus_irdy_i,
    input logic trdy_i,
    input logic stop_i,
    input logic devsel_i,
    input logic hd_pop_o,
    input logic hd_valid_i
);

    // R3
    addr_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_o) |-> $past(gnt_i && !bus_frame_i && !bus_irdy_i));

    // R4
    data_after_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_o) |=> irdy_o);

    // R5
    last_phase_irdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(frame_o) && !$past(stop_i)) |-> irdy_o);

    // R5
    irdy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irdy_o && !frame_o && trdy_i && devsel_i) |=> !irdy_o);

    // R11
    pop_with_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hd_pop_o |-> hd_valid_i);

endmodule

bind pw_master_seq pw_master_seq_chk u_chk (.*);

// File: tb/pw_master_seq_test.sv
module pw_master_seq_test;

    localparam int EV_NONE  = 0;
    localparam int EV_RETRY = 1;
    localparam int EV_DISC  = 2;
    localparam int EV_ABORT = 3;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n;
    logic        hd_valid, hd_more, hd_last, hd_pop;
    logic [31:0] hd_data, hd_addr, ad;
    logic [7:0]  lat;
    logic        req, gnt, frame, irdy, trdy, stop, devsel;
    logic        ext_busy;
    logic        bus_frame, bus_irdy;

    int total = 0;
    int bad   = 0;

    // queue model
    logic [31:0] fq_d [64];
    logic [31:0] fq_a [64];
    logic        fq_l [64];
    int wp = 0;
    int rp = 0;
    logic underflow = 1'b0;

    assign hd_valid = (wp - rp) > 0;
    assign hd_more  = (wp - rp) > 1;
    assign hd_data  = fq_d[rp % 64];
    assign hd_addr  = fq_a[rp % 64];
    assign hd_last  = fq_l[rp % 64];

    always @(posedge clk) begin
        if (hd_pop) begin
            if (wp <= rp) underflow <= 1'b1;
            rp <= rp + 1;
        end
    end

    // target model
    int ev = EV_NONE;
    int ev_at = 0;
    int arm_id = 0;
    int fired_id = 0;
    int pidx = 0;
    logic hit;

    assign hit    = irdy && (arm_id != fired_id) && (pidx == ev_at) && (ev != EV_NONE);
    assign devsel = irdy && !(hit && ev == EV_ABORT);
    assign trdy   = irdy && !(hit && (ev == EV_RETRY || ev == EV_ABORT));
    assign stop   = hit;

    always @(posedge clk) begin
        if (frame && !irdy) pidx <= 0;
        else if (irdy && (trdy || stop)) pidx <= pidx + 1;
        if (hit) fired_id <= arm_id;
    end

    assign bus_frame = frame | ext_busy;
    assign bus_irdy  = irdy;

    // bus log
    logic [31:0] la [32];
    int          lb [32];
    logic [31:0] ld [128];
    int na = 0;
    int nd = 0;

    always @(negedge clk) begin
        if (rst_n && frame && !irdy) begin
            la[na % 32] <= ad;
            lb[na % 32] <= nd;
            na <= na + 1;
        end
        if (rst_n && irdy && trdy && devsel) begin
            ld[nd % 128] <= ad;
            nd <= nd + 1;
        end
    end

    pw_master_seq uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .hd_valid_i  (hd_valid),
        .hd_more_i   (hd_more),
        .hd_data_i   (hd_data),
        .hd_last_i   (hd_last),
        .hd_addr_i   (hd_addr),
        .hd_pop_o    (hd_pop),
        .lat_timer_i (lat),
        .req_o       (req),
        .gnt_i       (gnt),
        .bus_frame_i (bus_frame),
        .bus_irdy_i  (bus_irdy),
        .frame_o     (frame),
        .irdy_o      (irdy),
        .ad_o        (ad),
        .trdy_i      (trdy),
        .stop_i      (stop),
        .devsel_i    (devsel)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic sync();
        @(posedge clk);
        #2;
    endtask

    task automatic push(input logic [31:0] a, input logic [31:0] d, input logic l);
        fq_a[wp % 64] = a;
        fq_d[wp % 64] = d;
        fq_l[wp % 64] = l;
        wp = wp + 1;
    endtask

    task automatic push_txn(input logic [31:0] a, input logic [31:0] v0, input int n, input bit ends);
        for (int k = 0; k < n; k++) push(a, v0 + k, ends && (k == n - 1));
    endtask

    task automatic arm(input int kind, input int at);
        ev     = kind;
        ev_at  = at;
        arm_id = arm_id + 1;
    endtask

    task automatic wait_quiet();
        int q = 0;
        for (int i = 0; i < 400 && q < 4; i++) begin
            @(negedge clk);
            if (wp == rp && !frame && !irdy) q++;
            else q = 0;
        end
    endtask

    task automatic chk_seq(input int from, input int n, input logic [31:0] v0, input string rq);
        for (int k = 0; k < n; k++)
            chk(ld[(from + k) % 128] == v0 + k, rq, "data word", ld[(from + k) % 128], v0 + k);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!req && !frame && !irdy && !hd_pop, "R1", "outputs after reset",
            {28'd0, req, frame, irdy, hd_pop}, 32'd0);
    endtask

    task automatic t_basic();
        int d0;
        d0 = nd;
        sync();
        push_txn(32'h0000_1000, 32'hA000_0000, 4, 1'b1);
        @(negedge clk); chk(req == 1'b0, "R2", "req before edge", {31'd0, req}, 32'd0);
        @(negedge clk); chk(req == 1'b1, "R2", "req one clock later", {31'd0, req}, 32'd1);
        @(negedge clk); chk(frame && !irdy, "R3", "address phase", {30'd0, frame, irdy}, 32'd2);
        chk(ad == 32'h0000_1000, "R3", "address value", ad, 32'h0000_1000);
        @(negedge clk); chk(frame && irdy && ad == 32'hA000_0000, "R4", "first word", ad, 32'hA000_0000);
        @(negedge clk); chk(ad == 32'hA000_0001, "R4", "second word no wait", ad, 32'hA000_0001);
        @(negedge clk);
        @(negedge clk); chk(!frame && irdy, "R5", "last phase signals", {30'd0, frame, irdy}, 32'd1);
        chk(ad == 32'hA000_0003, "R5", "last word", ad, 32'hA000_0003);
        @(negedge clk); chk(!irdy, "R5", "irdy released", {31'd0, irdy}, 32'd0);
        wait_quiet();
        chk_seq(d0, 4, 32'hA000_0000, "R4");
    endtask

    task automatic t_dry();
        int a0, d0;
        a0 = na; d0 = nd;
        sync();
        push_txn(32'h0000_2000, 32'hB000_0000, 2, 1'b0);
        wait_quiet();
        chk(na - a0 == 1, "R6", "one burst while dry", na - a0, 1);
        chk(nd - d0 == 2, "R6", "words before dry", nd - d0, 2);
        sync();
        push_txn(32'h0000_2000, 32'hB000_0002, 2, 1'b1);
        wait_quiet();
        chk(na - a0 == 2, "R6", "follow-on burst", na - a0, 2);
        chk(la[(a0 + 1) % 32] == 32'h0000_2008, "R6", "resume address", la[(a0 + 1) % 32], 32'h0000_2008);
        chk_seq(d0, 4, 32'hB000_0000, "R6");
    endtask

    task automatic t_retry();
        int a0, d0;
        a0 = na; d0 = nd;
        arm(EV_RETRY, 1);
        sync();
        push_txn(32'h0000_3000, 32'hC000_0000, 3, 1'b1);
        wait_quiet();
        chk(na - a0 == 2, "R7", "bursts after retry", na - a0, 2);
        chk(la[(a0 + 1) % 32] == 32'h0000_3004, "R7", "retry resume address", la[(a0 + 1) % 32], 32'h0000_3004);
        chk(nd - d0 == 3, "R7", "words delivered", nd - d0, 3);
        chk_seq(d0, 3, 32'hC000_0000, "R7");
    endtask

    task automatic t_disc();
        int a0, d0;
        a0 = na; d0 = nd;
        arm(EV_DISC, 1);
        sync();
        push_txn(32'h0000_4000, 32'hD000_0000, 4, 1'b1);
        wait_quiet();
        chk(na - a0 == 2, "R8", "bursts after disconnect", na - a0, 2);
        chk(la[(a0 + 1) % 32] == 32'h0000_4008, "R8", "disconnect resume address", la[(a0 + 1) % 32], 32'h0000_4008);
        chk(nd - d0 == 4, "R8", "words delivered", nd - d0, 4);
        chk_seq(d0, 4, 32'hD000_0000, "R8");
    endtask

    task automatic t_abort();
        int a0, d0;
        a0 = na; d0 = nd;
        arm(EV_ABORT, 1);
        sync();
        push_txn(32'h0000_5000, 32'hE000_0000, 4, 1'b1);
        push_txn(32'h0000_6000, 32'hF000_0000, 2, 1'b1);
        wait_quiet();
        chk(na - a0 == 2, "R9", "bursts around abort", na - a0, 2);
        chk(la[(a0 + 1) % 32] == 32'h0000_6000, "R9", "next write address", la[(a0 + 1) % 32], 32'h0000_6000);
        chk(nd - d0 == 3, "R9", "words delivered", nd - d0, 3);
        chk(ld[d0 % 128] == 32'hE000_0000, "R9", "word before abort", ld[d0 % 128], 32'hE000_0000);
        chk_seq(d0 + 1, 2, 32'hF000_0000, "R9");
        chk(wp == rp, "R9", "discarded words popped", rp, wp);
    endtask

    task automatic t_latency();
        int a0, d0, n1;
        a0 = na; d0 = nd;
        lat = 8'd2;
        sync();
        push_txn(32'h0000_7000, 32'h7000_0000, 6, 1'b1);
        for (int i = 0; i < 50 && !(frame && !irdy); i++) @(negedge clk);
        gnt = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 50 && (frame || irdy); i++) @(negedge clk);
        gnt = 1'b1;
        wait_quiet();
        n1 = lb[(a0 + 1) % 32] - lb[a0 % 32];
        chk(na - a0 == 2, "R10", "bursts with grant lost", na - a0, 2);
        chk(n1 == 3, "R10", "first burst length", n1, 3);
        chk(la[(a0 + 1) % 32] == 32'h0000_700C, "R10", "resume after grant loss", la[(a0 + 1) % 32], 32'h0000_700C);
        chk_seq(d0, 6, 32'h7000_0000, "R10");
        a0 = na;
        lat = 8'd1;
        sync();
        push_txn(32'h0000_7100, 32'h7100_0000, 6, 1'b1);
        wait_quiet();
        chk(na - a0 == 1, "R10", "grant kept keeps burst", na - a0, 1);
        lat = 8'd64;
    endtask

    task automatic t_busy();
        int a0, d0;
        a0 = na; d0 = nd;
        ext_busy = 1'b1;
        sync();
        push_txn(32'h0000_8000, 32'h8000_0000, 1, 1'b1);
        repeat (5) @(negedge clk);
        chk(!frame && req, "R3", "held off by busy bus", {30'd0, frame, req}, 32'd1);
        ext_busy = 1'b0;
        wait_quiet();
        chk(na - a0 == 1 && la[a0 % 32] == 32'h0000_8000, "R3", "address after bus idle", la[a0 % 32], 32'h0000_8000);
        chk_seq(d0, 1, 32'h8000_0000, "R3");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total + 1, bad + 1);
        $finish;
    end

    initial begin
        rst_n    = 1'b0;
        gnt      = 1'b1;
        ext_busy = 1'b0;
        lat      = 8'd64;
        repeat (2) @(negedge clk);
        chk(!req && !frame && !irdy && !hd_pop, "R1", "outputs in reset",
            {28'd0, req, frame, irdy, hd_pop}, 32'd0);
        sync();
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_dry();
        t_retry();
        t_disc();
        t_abort();
        t_latency();
        t_busy();
        chk(!underflow && wp == rp, "R11", "no pop from empty queue", {31'd0, underflow}, 32'd0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule